// File: doc/BRIEF.md
# Out-of-Order Trigger Decision Reorderer

This block sits between a farm of processors that judge first-level-accepted events and the front-end buffers that hold those events. Each first-level accept takes the next free event number from a circular table of 1024 slots. The processors return accept/reject verdicts tagged with that number, in whatever order their work finishes. The block stores each verdict in its slot and releases verdicts strictly in the order the events were first accepted. Released verdicts are spaced at least 36 clocks apart, which is 900 ns at 40 MHz, so the front-end buffers always have time to empty between two verdicts.

The block counts the events that are still waiting for release. When that count reaches a programmable level, it raises a hold signal that tells the first-level trigger to stop accepting. The count never goes above 1000. A throttle input from downstream buffers turns any accept verdict released while it is high into a reject. A verdict that names a slot that is empty, or a slot that already has a verdict, is dropped and raises a sticky error flag.

Top module: `decision_reorder`

## Requirements
- R1: After reset, out_valid, hold_accepts and err_flag are 0, occupancy is 0 and alloc_id is 0.
- R2: Each cycle with acc_valid high and occupancy below 1000 takes event number alloc_id. Event numbers start at 0 after reset and step by one modulo 1024, so 1023 is followed by 0.
- R3: Verdicts come out on out_id in exactly the order of the event numbers: one per event, with no skips and no repeats.
- R4: The oldest pending event blocks all release until its verdict arrives, even when verdicts for later events are already stored.
- R5: Two consecutive out_valid pulses are at least 36 cycles apart. When the next verdict is already waiting, the gap is exactly 36 cycles.
- R6: dec_accept encodes 1 as accept and 0 as reject. out_accept is the stored verdict ANDed with the inverse of thr_in, with thr_in sampled in the cycle before out_valid rises. A reject always comes out as a reject.
- R7: occupancy equals the number of accepted events minus the number of released events and never goes above 1000. An accept presented while occupancy is 1000 is ignored: no number is taken and occupancy stays the same.
- R8: hold_accepts is 1 exactly when occupancy is greater than or equal to the level register. The level register resets to 984 and is loaded from cfg_level in a cycle with cfg_we high.
- R9: A verdict for a slot that is not allocated, or for a slot that already has a verdict, sets err_flag until reset. That verdict is dropped: it produces no output and does not change the verdict already stored in the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | First-level accept; takes the next event number |
| alloc_id | output | 10 | Event number taken by an accept in this cycle |
| dec_valid | input | 1 | Verdict strobe from the processor farm |
| dec_id | input | 10 | Event number the verdict belongs to |
| dec_accept | input | 1 | Verdict: 1 accept, 0 reject |
| thr_in | input | 1 | Downstream throttle; turns released accepts into rejects |
| cfg_we | input | 1 | Load strobe for the near-full level |
| cfg_level | input | 10 | New near-full level |
| out_valid | output | 1 | One-cycle pulse for a released verdict |
| out_id | output | 10 | Event number of the released verdict |
| out_accept | output | 1 | Released verdict after throttling |
| occupancy | output | 10 | Events accepted but not yet released |
| hold_accepts | output | 1 | Near-full: block further first-level accepts |
| err_flag | output | 1 | Sticky flag for a dropped verdict |

## Verification
Corruption in the slot table shows at the ports in one of three ways: a skipped or repeated out_id, a verdict value different from the one sent, or a release that stalls until the run times out. Each of these is caught on the next out_valid pulse. A wrong pacing count shows up as a gap other than 36 cycles between verdicts that were already waiting. A wrong occupancy count shows up within one cycle on occupancy, on hold_accepts, or in whether an accept at the ceiling takes a number. The bench fills the table to its ceiling, sweeps the near-full boundary one accept at a time, and wraps the event numbers past 1023.

// File: rtl/reord_pkg.sv
package reord_pkg;
  typedef enum logic {
    VERDICT_REJECT = 1'b0,
    VERDICT_ACCEPT = 1'b1
  } verdict_t;
endpackage

// File: rtl/reord_table.sv
module reord_table
  import reord_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_id,
  input  logic             dec_en,
  input  logic [IDX_W-1:0] dec_id,
  input  logic             dec_acc,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] look_id,
  output logic             head_ready,
  output verdict_t         head_verdict,
  output logic             dec_bad
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] used_q, used_d;
  logic [DEPTH-1:0] done_q, done_d;
  verdict_t         vrd_q [DEPTH];
  logic             dec_ok;

  assign dec_ok       = dec_en && used_q[dec_id] && !done_q[dec_id];
  assign dec_bad      = dec_en && !dec_ok;
  assign head_ready   = used_q[look_id] && done_q[look_id];
  assign head_verdict = vrd_q[look_id];

  always_comb begin
    used_d = used_q;
    done_d = done_q;
    if (rel_en) begin
      used_d[look_id] = 1'b0;
      done_d[look_id] = 1'b0;
    end
    if (alloc_en) used_d[alloc_id] = 1'b1;
    if (dec_ok)   done_d[dec_id]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      done_q <= '0;
    end else begin
      used_q <= used_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dec_ok) vrd_q[dec_id] <= verdict_t'(dec_acc);
  end

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !used_q[alloc_id]);
  // R9
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_bad && used_q[dec_id]) |=> done_q[$past(dec_id)]);
  // R4
  head_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> (used_q[look_id] && done_q[look_id]));
endmodule

// File: rtl/reord_pacer.sv
module reord_pacer #(
  parameter int SPACING = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ready
);
  if (SPACING > 1) begin : g_count
    localparam int CNT_W = $clog2(SPACING);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (fire)              cnt_d = CNT_W'(SPACING - 1);
      else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

    // R5
    pace_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !ready);
  end else begin : g_free
    assign ready = 1'b1;
  end
endmodule

// File: rtl/reord_occ.sv
module reord_occ #(
  parameter int MAX_PEND = 1000,
  parameter int OCC_W    = 10,
  parameter int LVL_RST  = 984
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             cfg_we,
  input  logic [OCC_W-1:0] cfg_level,
  output logic [OCC_W-1:0] occ,
  output logic             full,
  output logic             near_full
);
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [OCC_W-1:0] lvl_q, lvl_d;

  always_comb begin
    occ_d = occ_q;
    case ({inc, dec})
      2'b10:   occ_d = occ_q + OCC_W'(1);
      2'b01:   occ_d = occ_q - OCC_W'(1);
      default: occ_d = occ_q;
    endcase
    lvl_d = cfg_we ? cfg_level : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      lvl_q <= OCC_W'(LVL_RST);
    end else begin
      occ_q <= occ_d;
      lvl_q <= lvl_d;
    end
  end

  assign occ       = occ_q;
  assign full      = (occ_q == OCC_W'(MAX_PEND));
  assign near_full = (occ_q >= lvl_q);

  // R7
  occ_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(MAX_PEND));
  // R7
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inc);
  // R7
  occ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(occ_q));
endmodule

// File: rtl/decision_reorder.sv
module decision_reorder
  import reord_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int MAX_PEND = 1000,
  parameter int SPACING  = 36,
  parameter int NEAR_GAP = 16,
  localparam int OCC_W   = $clog2(MAX_PEND + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic [IDX_W-1:0] alloc_id,
  input  logic             dec_valid,
  input  logic [IDX_W-1:0] dec_id,
  input  logic             dec_accept,
  input  logic             thr_in,
  input  logic             cfg_we,
  input  logic [OCC_W-1:0] cfg_level,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_id,
  output logic             out_accept,
  output logic [OCC_W-1:0] occupancy,
  output logic             hold_accepts,
  output logic             err_flag
);
  localparam int GAP_W = $clog2(SPACING + 1);

  logic [1:0]       rsync_q;
  logic             rst_s_n;
  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic             alloc_en, rel_fire, full, pace_ready;
  logic             head_ready, dec_bad;
  verdict_t         head_verdict;
  logic             ov_q, ov_d, oa_q, oa_d, err_q, err_d;
  logic [IDX_W-1:0] oid_q, oid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign alloc_en = acc_valid && !full;
  assign rel_fire = head_ready && pace_ready;

  reord_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_s_n),
    .alloc_en(alloc_en), .alloc_id(tail_q),
    .dec_en(dec_valid), .dec_id(dec_id), .dec_acc(dec_accept),
    .rel_en(rel_fire), .look_id(head_q),
    .head_ready(head_ready), .head_verdict(head_verdict), .dec_bad(dec_bad)
  );

  reord_pacer #(.SPACING(SPACING)) u_pacer (
    .clk(clk), .rst_n(rst_s_n), .fire(rel_fire), .ready(pace_ready)
  );

  reord_occ #(.MAX_PEND(MAX_PEND), .OCC_W(OCC_W), .LVL_RST(MAX_PEND - NEAR_GAP)) u_occ (
    .clk(clk), .rst_n(rst_s_n), .inc(alloc_en), .dec(rel_fire),
    .cfg_we(cfg_we), .cfg_level(cfg_level),
    .occ(occupancy), .full(full), .near_full(hold_accepts)
  );

  always_comb begin
    tail_d = alloc_en ? tail_q + IDX_W'(1) : tail_q;
    head_d = rel_fire ? head_q + IDX_W'(1) : head_q;
    ov_d   = rel_fire;
    oid_d  = rel_fire ? head_q : oid_q;
    oa_d   = rel_fire ? ((head_verdict == VERDICT_ACCEPT) && !thr_in) : oa_q;
    err_d  = err_q || dec_bad;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tail_q <= '0;
      head_q <= '0;
      ov_q   <= 1'b0;
      oid_q  <= '0;
      oa_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      tail_q <= tail_d;
      head_q <= head_d;
      ov_q   <= ov_d;
      oid_q  <= oid_d;
      oa_q   <= oa_d;
      err_q  <= err_d;
    end
  end

  assign alloc_id   = tail_q;
  assign out_valid  = ov_q;
  assign out_id     = oid_q;
  assign out_accept = oa_q;
  assign err_flag   = err_q;

  // Checker state: cycles since last release, and the next expected event number
  logic [GAP_W-1:0] gap_q;
  logic [IDX_W-1:0] seq_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gap_q <= GAP_W'(SPACING);
      seq_q <= '0;
    end else begin
      if (ov_q)                           gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(SPACING))  gap_q <= gap_q + GAP_W'(1);
      if (ov_q) seq_q <= seq_q + IDX_W'(1);
    end
  end

  // R5
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ov_q |-> (gap_q == GAP_W'(SPACING)));
  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ov_q |-> (oid_q == seq_q));
  // R6
  throttle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ov_q && oa_q) |-> !$past(thr_in));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_q |=> err_q);
endmodule

// File: tb/decision_reorder_tb.sv
module decision_reorder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       dec_valid = 1'b0;
  logic [9:0] dec_id = '0;
  logic       dec_accept = 1'b0;
  logic       thr_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_level = '0;
  logic [9:0] alloc_id, out_id, occupancy;
  logic       out_valid, out_accept, hold_accepts, err_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_next = 0;
  int n_out = 0;
  int last_cyc = 0;
  bit exp_acc [1024];
  bit done_flag = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  decision_reorder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .alloc_id(alloc_id),
    .dec_valid(dec_valid), .dec_id(dec_id), .dec_accept(dec_accept),
    .thr_in(thr_in), .cfg_we(cfg_we), .cfg_level(cfg_level),
    .out_valid(out_valid), .out_id(out_id), .out_accept(out_accept),
    .occupancy(occupancy), .hold_accepts(hold_accepts), .err_flag(err_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk("R3 order", out_id, exp_next % 1024);
      chk("R6 verdict", out_accept, exp_acc[out_id]);
      if (n_out > 0) chk("R5 gap", cyc - last_cyc, 36);
      last_cyc = cyc;
      n_out++;
      exp_next++;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    acc_valid = 1'b0; dec_valid = 1'b0; thr_in = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_next = 0;
    n_out = 0;
  endtask

  task automatic do_accept(input int exp_id);
    chk("R2 number", alloc_id, exp_id % 1024);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_dec(input int id, input bit a, input bit good);
    dec_valid = 1'b1; dec_id = 10'(id); dec_accept = a;
    if (good) exp_acc[id] = a & ~thr_in;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic wait_outs(input string req, input int n, input int limit);
    int t = 0;
    while (n_out < n && t < limit) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(req, n_out, n);
  endtask

  task automatic set_level(input int v);
    cfg_we = 1'b1; cfg_level = 10'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 occupancy", occupancy, 0);
    chk("R1 hold", hold_accepts, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 alloc_id", alloc_id, 0);

    // Reverse-order verdicts; the oldest arrives last
    for (int i = 0; i < 8; i++) do_accept(i);
    chk("R7 occupancy after 8", occupancy, 8);
    for (int i = 7; i >= 1; i--) do_dec(i, (i % 3) == 0, 1'b1);
    repeat (60) @(negedge clk);
    chk("R4 head blocks", n_out, 0);
    do_dec(0, 1'b1, 1'b1);
    wait_outs("R3 count A", 8, 400);
    chk("R7 occupancy drained", occupancy, 0);

    // Throttle turns accepts into rejects
    n_out = 0;
    thr_in = 1'b1;
    for (int i = 8; i < 12; i++) do_accept(i);
    for (int i = 8; i < 12; i++) do_dec(i, 1'b1, 1'b1);
    wait_outs("R6 count throttled", 4, 300);
    thr_in = 1'b0;
    n_out = 0;
    for (int i = 12; i < 14; i++) do_accept(i);
    for (int i = 12; i < 14; i++) do_dec(i, 1'b1, 1'b1);
    wait_outs("R6 count open", 2, 200);

    // Second verdict for an already-decided slot is dropped
    n_out = 0;
    do_accept(14);
    do_accept(15);
    do_dec(15, 1'b0, 1'b1);
    chk("R9 no err yet", err_flag, 0);
    do_dec(15, 1'b1, 1'b0);
    chk("R9 err on repeat", err_flag, 1);
    repeat (20) @(negedge clk);
    chk("R9 no output", n_out, 0);
    do_dec(14, 1'b1, 1'b1);
    wait_outs("R9 count", 2, 200);

    // Verdict for an empty slot
    do_reset();
    do_dec(3, 1'b1, 1'b0);
    chk("R9 err on empty", err_flag, 1);
    repeat (40) @(negedge clk);
    chk("R9 empty no output", n_out, 0);
    chk("R9 empty occupancy", occupancy, 0);
    repeat (5) @(negedge clk);
    chk("R9 sticky", err_flag, 1);

    // Fill to the ceiling and sweep the near-full boundary
    do_reset();
    for (int k = 1; k <= 1000; k++) begin
      do_accept(k - 1);
      chk("R7 occupancy fill", occupancy, k);
      chk("R8 hold fill", hold_accepts, (k >= 984) ? 1 : 0);
    end
    do_accept(1000);
    chk("R7 no number at ceiling", alloc_id, 1000);
    chk("R7 occupancy at ceiling", occupancy, 1000);
    set_level(1001);
    chk("R8 level above", hold_accepts, 0);
    set_level(500);
    chk("R8 level below", hold_accepts, 1);
    for (int i = 0; i < 1000; i++) do_dec(i, (i % 2) == 0, 1'b1);
    wait_outs("R3 count drain", 1000, 40000);
    chk("R7 occupancy empty", occupancy, 0);
    chk("R8 hold empty", hold_accepts, 0);

    // Event numbers wrap past 1023
    n_out = 0;
    set_level(984);
    for (int i = 0; i < 30; i++) do_accept(1000 + i);
    chk("R2 wrap number", alloc_id, 6);
    for (int i = 29; i >= 0; i--) do_dec((1000 + i) % 1024, (i % 4) != 1, 1'b1);
    wait_outs("R3 count wrap", 30, 1500);
    chk("R7 occupancy after wrap", occupancy, 0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule